// File: doc/BRIEF.md
# Fixed-Point Float/Integer Converter

This block converts in both directions between IEEE-754 single-precision values and 32-bit integers. The integer side is treated as a fixed-point number whose binary point is chosen at run time: a 5-bit position gives the number of low integer bits that hold fraction. Float-to-integer scales by two to that power and truncates toward zero. Integer-to-float divides by the same power and rounds to nearest-even.

A signed/unsigned selector applies to both directions. In float-to-integer it picks the target range. In integer-to-float it picks how the 32-bit source is read. Each result carries two status bits. One marks a value outside the representable range, in which case the output saturates. The other marks nonzero bits that were dropped.

Both converters work in parallel on the same input, and the direction bit picks one of the two results. With the default parameters the result is registered, so it appears one cycle after the input strobe.

Top module: `fxp_float_conv`

## Requirements
- R1: A result and `out_vld` appear exactly one clock after a cycle with `in_vld` high. `out_vld` is low after any cycle with `in_vld` low, and the outputs then keep their last values. Reset clears `out_vld`, `out_data`, `out_ovf` and `out_inexact` to 0.
- R2: With `in_dir`=0 (float to integer), the float is multiplied by 2^`in_fpos` (`in_fpos` 0..31) and truncated toward zero. `in_signed`=1 selects a two's-complement result and 0 selects an unsigned result.
- R3: In float to integer, a value outside the selected range sets `out_ovf` and saturates the result. Signed results saturate to 0x7FFFFFFF or 0x80000000. Unsigned results saturate high to 0xFFFFFFFF.
- R4: In an unsigned float-to-integer conversion, a negative value whose truncated magnitude is nonzero gives 0 and sets `out_ovf`. A negative value that truncates to zero magnitude, including -0.0, gives 0 without `out_ovf`.
- R5: A NaN converted to an integer gives 0 with `out_ovf` set. An infinity saturates by its sign as in R3.
- R6: `out_inexact` is set when a conversion drops nonzero bits below the result's last place. When `out_ovf` is set, `out_inexact` is 0.
- R7: With `in_dir`=1 (integer to float), the source is read as two's complement when `in_signed`=1 and as unsigned when `in_signed`=0. The result is the value divided by 2^`in_fpos`.
- R8: Integer to float rounds to nearest, ties to even, when the magnitude needs more than 24 significant bits, and sets `out_inexact` when rounding drops nonzero bits. This direction never sets `out_ovf`.
- R9: An integer source of 0 converts to +0.0 (0x00000000) with no status bit set.
- R10: Subnormal float inputs are converted by their true value, so every nonzero subnormal gives 0 with `out_inexact` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Input strobe; the operands are taken in this cycle |
| in_dir | input | 1 | 0: float to integer, 1: integer to float |
| in_signed | input | 1 | 1: signed integer side, 0: unsigned |
| in_fpos | input | 5 | Number of fraction bits on the integer side |
| in_data | input | 32 | Operand: float bits or integer bits |
| out_vld | output | 1 | Result strobe |
| out_data | output | 32 | Result: integer bits or float bits |
| out_ovf | output | 1 | Range overflow; the result is saturated |
| out_inexact | output | 1 | Nonzero bits were discarded |

## Verification
Overflow detection and lost-fraction detection can both trigger in the same conversion. A negative float with a fraction converted as unsigned (-1.5) is out of range and also loses its fraction. The bench drives such operands and expects only `out_ovf`, which confirms the priority rule of R6. The two converter directions can also meet in adjacent cycles. Back-to-back strobes that alternate `in_dir` check that each registered result matches the direction given in its own input cycle.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned EXP_W  = 8;
   localparam int unsigned MAN_W  = 23;
   localparam int unsigned SIG_W  = MAN_W + 1;
   localparam int unsigned BIAS   = 127;
   localparam int unsigned POS_W  = $clog2(WORD_W);

   typedef struct packed {
      logic [WORD_W-1:0] data;
      logic              ovf;
      logic              inx;
   } cvt_res_t;

   // saturation value for an out-of-range float-to-integer result
   function automatic logic [WORD_W-1:0] sat_word(input logic neg, input logic sgn);
      logic [WORD_W-1:0] w;
      if (sgn) w = neg ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
      else     w = neg ? '0 : '1;
      return w;
   endfunction

endpackage

// File: rtl/fxc_lzc.sv
module fxc_lzc #(
   parameter int unsigned W = 32,
   localparam int unsigned CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt,
   output logic          all_zero
);

   if (W < 2) begin : g_bad_w
      $error("fxc_lzc: W must be at least 2");
   end

   always_comb begin
      cnt = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) cnt = CW'(W - 1 - i);
      end
   end

   assign all_zero = ~|vec;

endmodule

// File: rtl/fxc_f2i.sv
module fxc_f2i
   import fxc_pkg::*;
(
   input  logic [WORD_W-1:0] val,
   input  logic              sgn,
   input  logic [POS_W-1:0]  fpos,
   output cvt_res_t          res
);

   localparam int unsigned HEAD  = WORD_W + 1 - SIG_W;  // left shifts that still fit 33 bits
   localparam int unsigned MAG_W = WORD_W + 1;

   logic              neg;
   logic [EXP_W-1:0]  bexp;
   logic [MAN_W-1:0]  frac;
   logic              is_nan, is_inf;
   logic [SIG_W-1:0]  sig;
   logic [EXP_W-1:0]  eexp;
   logic signed [10:0] sh;
   logic [10:0]       rs;
   logic [MAG_W-1:0]  mag;
   logic              big, lost;

   assign neg    = val[WORD_W-1];
   assign bexp   = val[WORD_W-2 -: EXP_W];
   assign frac   = val[MAN_W-1:0];
   assign is_nan = (&bexp) && (frac != '0);
   assign is_inf = (&bexp) && (frac == '0);
   assign sig    = {(bexp != '0), frac};
   assign eexp   = (bexp == '0) ? EXP_W'(1) : bexp;

   // value = sig * 2^(eexp - BIAS - MAN_W + fpos)
   assign sh = $signed({3'b000, eexp}) + $signed({6'b0, fpos})
             - $signed(11'(BIAS + MAN_W));
   assign rs = 11'(-sh);

   always_comb begin
      mag  = '0;
      big  = 1'b0;
      lost = 1'b0;
      if (sh >= 11'sd0) begin
         if (sh > 11'(HEAD)) big = (sig != '0);
         else                mag = {{(MAG_W-SIG_W){1'b0}}, sig} << sh[3:0];
      end else if (rs >= 11'(SIG_W)) begin
         lost = (sig != '0);
      end else begin
         mag  = MAG_W'(sig >> rs[4:0]);
         lost = |(sig & ~({SIG_W{1'b1}} << rs[4:0]));
      end
   end

   always_comb begin
      res.data = '0;
      res.ovf  = 1'b0;
      res.inx  = 1'b0;
      if (is_nan) begin
         res.ovf = 1'b1;
      end else if (is_inf || big) begin
         res.ovf  = 1'b1;
         res.data = sat_word(neg, sgn);
      end else if (!sgn) begin
         if (neg) begin
            if (mag != '0) res.ovf = 1'b1;
            else           res.inx = lost;
         end else if (mag[WORD_W]) begin
            res.ovf  = 1'b1;
            res.data = sat_word(1'b0, 1'b0);
         end else begin
            res.data = mag[WORD_W-1:0];
            res.inx  = lost;
         end
      end else begin
         if (!neg && (mag[WORD_W] || mag[WORD_W-1])) begin
            res.ovf  = 1'b1;
            res.data = sat_word(1'b0, 1'b1);
         end else if (neg && (mag > {2'b01, {(WORD_W-1){1'b0}}})) begin
            res.ovf  = 1'b1;
            res.data = sat_word(1'b1, 1'b1);
         end else begin
            res.data = neg ? (~mag[WORD_W-1:0] + 1'b1) : mag[WORD_W-1:0];
            res.inx  = lost;
         end
      end
   end

endmodule

// File: rtl/fxc_i2f.sv
module fxc_i2f
   import fxc_pkg::*;
(
   input  logic [WORD_W-1:0] val,
   input  logic              sgn,
   input  logic [POS_W-1:0]  fpos,
   output cvt_res_t          res
);

   localparam int unsigned LZ_W  = $clog2(WORD_W + 1);
   localparam int unsigned GRD   = WORD_W - 2 - MAN_W;   // guard bit index after normalising
   localparam int unsigned TOP_E = BIAS + WORD_W - 1;    // biased exponent of an unscaled bit 31

   logic              neg;
   logic [WORD_W-1:0] mag, norm;
   logic [LZ_W-1:0]   lz;
   logic              zero;
   logic [MAN_W-1:0]  mant;
   logic              grd, stk, up;
   logic [MAN_W:0]    mant_r;
   logic [EXP_W:0]    e9;
   logic [EXP_W-1:0]  exp_f;

   assign neg = sgn & val[WORD_W-1];
   assign mag = neg ? (~val + 1'b1) : val;

   fxc_lzc #(.W(WORD_W)) u_lzc (
      .vec      (mag),
      .cnt      (lz),
      .all_zero (zero)
   );

   assign norm   = mag << lz[POS_W-1:0];
   assign mant   = norm[WORD_W-2 -: MAN_W];
   assign grd    = norm[GRD];
   assign stk    = |norm[GRD-1:0];
   assign up     = grd & (stk | mant[0]);
   assign mant_r = {1'b0, mant} + (MAN_W+1)'(up);
   assign e9     = (EXP_W+1)'(TOP_E) - (EXP_W+1)'(lz) - (EXP_W+1)'(fpos);
   assign exp_f  = e9[EXP_W-1:0] + EXP_W'(mant_r[MAN_W]);

   always_comb begin
      res.ovf = 1'b0;
      if (zero) begin
         res.data = '0;
         res.inx  = 1'b0;
      end else begin
         res.data = {neg, exp_f, mant_r[MAN_W-1:0]};
         res.inx  = grd | stk;
      end
   end

endmodule

// File: rtl/fxp_float_conv.sv
module fxp_float_conv
   import fxc_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned FPOS_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic              in_dir,
   input  logic              in_signed,
   input  logic [FPOS_W-1:0] in_fpos,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic              out_ovf,
   output logic              out_inexact
);

   if (DATA_W != WORD_W) begin : g_bad_width
      $error("fxp_float_conv: DATA_W must equal the single-precision word width");
   end

   cvt_res_t res_f2i, res_i2f, res_sel;

   fxc_f2i u_f2i (
      .val  (in_data),
      .sgn  (in_signed),
      .fpos (in_fpos),
      .res  (res_f2i)
   );

   fxc_i2f u_i2f (
      .val  (in_data),
      .sgn  (in_signed),
      .fpos (in_fpos),
      .res  (res_i2f)
   );

   assign res_sel = in_dir ? res_i2f : res_f2i;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld     <= 1'b0;
            out_data    <= '0;
            out_ovf     <= 1'b0;
            out_inexact <= 1'b0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               out_data    <= res_sel.data;
               out_ovf     <= res_sel.ovf;
               out_inexact <= res_sel.inx;
            end
         end
      end
   end else begin : g_comb
      assign out_vld     = in_vld;
      assign out_data    = res_sel.data;
      assign out_ovf     = res_sel.ovf;
      assign out_inexact = res_sel.inx;
   end

endmodule

// File: rtl/fxp_float_conv_chk.sv
module fxp_float_conv_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        in_vld,
   input logic        in_dir,
   input logic        in_signed,
   input logic [31:0] in_data,
   input logic        out_vld,
   input logic [31:0] out_data,
   input logic        out_ovf,
   input logic        out_inexact
);

   logic f2i_nan, uns_neg, i2f_zero;
   assign f2i_nan  = in_vld && !in_dir && (&in_data[30:23]) && (in_data[22:0] != '0);
   assign uns_neg  = in_vld && !in_dir && !in_signed && in_data[31];
   assign i2f_zero = in_vld && in_dir && (in_data == '0);

   // R6: the two status bits never appear together
   p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !(out_ovf && out_inexact));

   if (OUT_REG) begin : g_reg
      p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld);
      p_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> (!out_vld && $stable(out_data)));
      p_uns_neg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         uns_neg |=> (out_data == '0));
      p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
         f2i_nan |=> (out_ovf && out_data == '0));
      p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && in_dir) |=> !out_ovf);
      p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         i2f_zero |=> (out_data == '0 && !out_inexact));
   end else begin : g_comb
      p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |-> out_vld);
      p_uns_neg_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         uns_neg |-> (out_data == '0));
      p_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
         f2i_nan |-> (out_ovf && out_data == '0));
      p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && in_dir) |-> !out_ovf);
      p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
         i2f_zero |-> (out_data == '0 && !out_inexact));
   end

endmodule

bind fxp_float_conv fxp_float_conv_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_vld      (in_vld),
   .in_dir      (in_dir),
   .in_signed   (in_signed),
   .in_data     (in_data),
   .out_vld     (out_vld),
   .out_data    (out_data),
   .out_ovf     (out_ovf),
   .out_inexact (out_inexact)
);

// File: tb/test_fxp_float_conv.sv
module test_fxp_float_conv;

   localparam int CLK_P = 10;
   localparam int NV    = 31;

   typedef struct packed {
      logic        dir;
      logic        sgn;
      logic [4:0]  fpos;
      logic [31:0] din;
      logic [31:0] dout;
      logic        ovf;
      logic        inx;
      logic [3:0]  req;
   } vec_t;

   // dir 0 = float->int, 1 = int->float; sgn 1 = signed
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b1,5'd0, 32'h3F800000,32'h00000001,1'b0,1'b0,4'd2},   // R2  1.0
      '{1'b0,1'b1,5'd0, 32'h3FC00000,32'h00000001,1'b0,1'b1,4'd6},   // R6  1.5 loses half
      '{1'b0,1'b1,5'd1, 32'h3FC00000,32'h00000003,1'b0,1'b0,4'd2},   // R2  1.5 * 2
      '{1'b0,1'b1,5'd0, 32'hC0300000,32'hFFFFFFFE,1'b0,1'b1,4'd6},   // R6  -2.75 -> -2
      '{1'b0,1'b1,5'd2, 32'hC0300000,32'hFFFFFFF5,1'b0,1'b0,4'd2},   // R2  -2.75 * 4
      '{1'b0,1'b1,5'd0, 32'h4F000000,32'h7FFFFFFF,1'b1,1'b0,4'd3},   // R3  2^31 signed
      '{1'b0,1'b0,5'd0, 32'h4F000000,32'h80000000,1'b0,1'b0,4'd3},   // R3  2^31 unsigned
      '{1'b0,1'b1,5'd0, 32'hCF000000,32'h80000000,1'b0,1'b0,4'd3},   // R3  -2^31 fits
      '{1'b0,1'b0,5'd0, 32'h4F800000,32'hFFFFFFFF,1'b1,1'b0,4'd3},   // R3  2^32 unsigned
      '{1'b0,1'b0,5'd0, 32'hBF800000,32'h00000000,1'b1,1'b0,4'd4},   // R4  -1.0 unsigned
      '{1'b0,1'b0,5'd0, 32'hBF000000,32'h00000000,1'b0,1'b1,4'd4},   // R4  -0.5 unsigned
      '{1'b0,1'b1,5'd0, 32'h7FC00000,32'h00000000,1'b1,1'b0,4'd5},   // R5  NaN
      '{1'b0,1'b1,5'd0, 32'h7F800000,32'h7FFFFFFF,1'b1,1'b0,4'd5},   // R5  +inf
      '{1'b0,1'b1,5'd0, 32'hFF800000,32'h80000000,1'b1,1'b0,4'd5},   // R5  -inf
      '{1'b0,1'b1,5'd31,32'h3F800000,32'h7FFFFFFF,1'b1,1'b0,4'd3},   // R3  1.0 at 31 bits
      '{1'b0,1'b0,5'd31,32'h3F800000,32'h80000000,1'b0,1'b0,4'd2},   // R2  1.0 at 31 bits uns
      '{1'b0,1'b0,5'd4, 32'h3E800000,32'h00000004,1'b0,1'b0,4'd2},   // R2  0.25 * 16
      '{1'b0,1'b1,5'd31,32'h00000001,32'h00000000,1'b0,1'b1,4'd10},  // R10 subnormal
      '{1'b0,1'b0,5'd0, 32'h80000000,32'h00000000,1'b0,1'b0,4'd4},   // R4  -0.0 unsigned
      '{1'b0,1'b0,5'd0, 32'hBFC00000,32'h00000000,1'b1,1'b0,4'd6},   // R6  -1.5 uns: ovf wins
      '{1'b1,1'b1,5'd0, 32'h00000001,32'h3F800000,1'b0,1'b0,4'd7},   // R7  1
      '{1'b1,1'b1,5'd0, 32'h00000000,32'h00000000,1'b0,1'b0,4'd9},   // R9  zero
      '{1'b1,1'b1,5'd0, 32'hFFFFFFFF,32'hBF800000,1'b0,1'b0,4'd7},   // R7  -1 signed
      '{1'b1,1'b0,5'd0, 32'hFFFFFFFF,32'h4F800000,1'b0,1'b1,4'd8},   // R8  2^32-1 rounds up
      '{1'b1,1'b1,5'd0, 32'h80000000,32'hCF000000,1'b0,1'b0,4'd7},   // R7  -2^31
      '{1'b1,1'b1,5'd1, 32'h00000003,32'h3FC00000,1'b0,1'b0,4'd7},   // R7  3 / 2
      '{1'b1,1'b1,5'd31,32'h00000001,32'h30000000,1'b0,1'b0,4'd7},   // R7  2^-31
      '{1'b1,1'b0,5'd0, 32'h01000001,32'h4B800000,1'b0,1'b1,4'd8},   // R8  tie to even, down
      '{1'b1,1'b0,5'd0, 32'h01000003,32'h4B800002,1'b0,1'b1,4'd8},   // R8  tie to even, up
      '{1'b1,1'b0,5'd8, 32'h00FFFFFF,32'h477FFFFF,1'b0,1'b0,4'd7},   // R7  24 bits / 256
      '{1'b1,1'b0,5'd0, 32'h80000000,32'h4F000000,1'b0,1'b0,4'd7}    // R7  2^31 unsigned
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic        in_dir = 1'b0;
   logic        in_signed = 1'b0;
   logic [4:0]  in_fpos = '0;
   logic [31:0] in_data = '0;
   logic        out_vld;
   logic [31:0] out_data;
   logic        out_ovf;
   logic        out_inexact;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   fxp_float_conv i_fxp_float_conv (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dir(in_dir),
      .in_signed(in_signed), .in_fpos(in_fpos), .in_data(in_data),
      .out_vld(out_vld), .out_data(out_data), .out_ovf(out_ovf),
      .out_inexact(out_inexact)
   );

   task automatic check(input string req, input logic v, input logic [31:0] d,
                        input logic o, input logic x);
      checks++;
      if (out_vld !== v || out_data !== d || out_ovf !== o || out_inexact !== x) begin
         errors++;
         $display("FAIL %s: got vld=%b data=%h ovf=%b inx=%b, expected vld=%b data=%h ovf=%b inx=%b",
                  req, out_vld, out_data, out_ovf, out_inexact, v, d, o, x);
      end
   endtask

   task automatic drive(input vec_t v);
      in_vld    = 1'b1;
      in_dir    = v.dir;
      in_signed = v.sgn;
      in_fpos   = v.fpos;
      in_data   = v.din;
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_P * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 1'b0, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", 1'b0, 32'h0, 1'b0, 1'b0);

      // table walk: one strobe, result checked one cycle later
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         in_vld = 1'b0;
         check($sformatf("R%0d vector %0d", VECS[i].req, i), 1'b1,
               VECS[i].dout, VECS[i].ovf, VECS[i].inx);
      end

      // R1: idle cycle drops out_vld and holds the last result
      @(negedge clk);
      check("R1 hold", 1'b0, VECS[NV-1].dout, VECS[NV-1].ovf, VECS[NV-1].inx);

      // R1/R6: back-to-back strobes with alternating direction
      drive(VECS[19]);            // -1.5 unsigned: overflow and lost fraction together
      @(negedge clk);
      drive(VECS[23]);            // int->float with rounding
      check("R6 back-to-back first", 1'b1, 32'h00000000, 1'b1, 1'b0);
      @(negedge clk);
      drive(VECS[1]);             // float->int, inexact only
      check("R8 back-to-back second", 1'b1, 32'h4F800000, 1'b0, 1'b1);
      @(negedge clk);
      in_vld = 1'b0;
      check("R6 back-to-back third", 1'b1, 32'h00000001, 1'b0, 1'b1);

      // R4: inputs ignored while in_vld is low
      in_dir = 1'b0; in_signed = 1'b0; in_data = 32'hBF800000; in_fpos = 5'd0;
      @(negedge clk);
      check("R1 no strobe no update", 1'b0, 32'h00000001, 1'b0, 1'b1);

      // R3: signed negative just past the range with scaling (-1.0 * 2^31 fits, * 2^31 of -2.0 does not)
      drive('{1'b0,1'b1,5'd31,32'hC0000000,32'h0,1'b0,1'b0,4'd3});
      @(negedge clk);
      in_vld = 1'b0;
      check("R3 negative saturation", 1'b1, 32'h80000000, 1'b1, 1'b0);

      // R1: reset in mid-run clears the outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", 1'b0, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule